// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Signed Set-Less-Than

This block is a purely combinational arithmetic logic unit, `W` bits wide (32 by default), built from a chain of identical one-bit slices. Each slice holds a full adder and a four-way result multiplexer. The carry out of every slice feeds the carry in of the slice above it. A single `b_inv` control complements the second operand before it reaches any slice. Together with `carry_in`, this turns the adder into a subtractor.

Signed set-less-than needs no comparator. The operation runs the subtraction through the chain. The raw sign bit that the top slice's adder produces is then sent back to the `less` input of slice 0. The `less` inputs of all other slices are held at 0, so the result is 0 or 1. An overflow flag is taken from the top slice's carry in and carry out, and a zero flag reports an all-zero result.

The block is used as the execute stage of a simple processor datapath. The controller drives a 4-bit code `{1'b0, b_inv, op_sel}`, with these values:

| Operation | Code |
|---|---|
| AND | 0000 |
| OR | 0001 |
| ADD | 0010 |
| SUB | 0110 |
| SLT | 0111 |

The controller sets `carry_in` to 1 for SUB and SLT.

Top module: `bit_slice_alu`

## Requirements
- R1: With `op_sel`=0, `result` equals `opa & bx`, where `bx` is `~opb` when `b_inv`=1 and `opb` otherwise.
- R2: With `op_sel`=1, `result` equals `opa | bx`.
- R3: With `op_sel`=2, `result` equals `(opa + bx + carry_in) mod 2^W`.
- R4: With `b_inv`=1, `carry_in`=1 and `op_sel`=2 (code 0110), `result` equals `opa - opb mod 2^W`.
- R5: With `op_sel`=3, `result[W-1:1]` is 0 and `result[0]` is the raw sign bit of `opa + bx + carry_in`. Under code 0111 this bit is the signed `opa < opb`, except when the subtraction overflows. In that case the bit is the inverse of the true comparison; for example, maxint compared with minint gives 1.
- R6: `overflow` is 1 exactly when `opa` and `bx` have the same sign and the sign of `opa + bx + carry_in` differs from it. The flag reflects the adder for every `op_sel`.
- R7: When `opa` and `bx` have opposite signs, `overflow` is 0.
- R8: `carry_out` equals bit W of `opa + bx + carry_in` for every `op_sel`.
- R9: `zero` is 1 exactly when all W bits of `result` are 0, including for the set-less-than result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| b_inv | input | 1 | Complement the second operand in every slice |
| carry_in | input | 1 | Carry into slice 0 |
| op_sel | input | 2 | Slice result select: 0 AND, 1 OR, 2 sum, 3 less |
| result | output | W | Selected result |
| carry_out | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Signed overflow of the adder chain |
| zero | output | 1 | All result bits are 0 |

## Verification
The checker tests the following whenever its inputs settle:
- AND results never hold a 1 where the first operand holds a 0, and OR results never drop a 1 of the first operand.
- Set-less-than drives only bit 0.
- An overflow never appears for operands of opposite effective sign.
- An overflow on an add always shows a flipped sign.

Other behaviours need the bench's chosen operands, because they depend on exact values:
- the wrapped sums at the maxint and minint boundaries;
- the inverted set-less-than answer when the subtraction overflows;
- the carry out from an AND or OR;
- a zero flag raised by a wrapped sum.

// File: rtl/alu_pkg.sv
// Package: shared types for the bit-sliced ALU.
// Assumes: the slice result select is two bits wide and is decoded
// identically in every slice.
package alu_pkg;

    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;

endpackage

// File: rtl/alu_slice.sv
// Module: alu_slice
// One bit of the ALU. It holds a full adder on (a, optionally inverted b,
// cin) and a four-way mux that picks AND, OR, sum or the less input.
// When IS_TOP is set, the slice also exports its raw sum bit as set_out.
// Otherwise set_out is tied low.
// Assumes: b_inv and sel are shared by every slice of the chain.
module alu_slice
    import alu_pkg::*;
#(
    parameter bit IS_TOP = 1'b0
) (
    input  logic       a,
    input  logic       b,
    input  logic       b_inv,
    input  logic       cin,
    input  logic       less,
    input  slice_sel_e sel,
    output logic       res,
    output logic       cout,
    output logic       set_out
);

    logic bx;
    logic sum;

    // Operand conditioning: optional complement of b.
    assign bx   = b ^ b_inv;

    // Full adder: sum and majority carry.
    assign sum  = a ^ bx ^ cin;
    assign cout = (a & bx) | (a & cin) | (bx & cin);

    // Result multiplexer driven by the shared select.
    always_comb begin
        unique case (sel)
            SEL_AND:  res = a & bx;
            SEL_OR:   res = a | bx;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = 1'b0;
        endcase
    end

    // Only the most-significant slice drives the set feedback.
    generate
        if (IS_TOP) begin : g_set
            assign set_out = sum;
        end else begin : g_noset
            assign set_out = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/alu_ripple.sv
// Module: alu_ripple
// Chains W slices through a ripple carry. It feeds the top slice's raw
// sum bit back into the less input of slice 0 and holds every other less
// input at 0. It exports the carry into and out of the top slice for the
// flag logic.
// Assumes: W >= 2.
module alu_ripple
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         b_inv,
    input  logic         cin,
    input  slice_sel_e   sel,
    output logic [W-1:0] res,
    output logic         msb_cin,
    output logic         msb_cout
);

    localparam int unsigned TOP = W - 1;

    logic         carry [0:W];
    logic [W-1:0] less_in;
    logic [W-1:0] set_bits;
    logic         set_fb;

    // Chain entry: the external carry enters slice 0.
    assign carry[0] = cin;

    // Only the top slice drives a nonzero set bit, so the OR is its value.
    assign set_fb = |set_bits;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Less routing: slice 0 gets the sign feedback, the rest get 0.
            if (i == 0) begin : g_lsb
                assign less_in[i] = set_fb;
            end else begin : g_other
                assign less_in[i] = 1'b0;
            end

            alu_slice #(
                .IS_TOP (i == TOP)
            ) u_slice (
                .a       (a[i]),
                .b       (b[i]),
                .b_inv   (b_inv),
                .cin     (carry[i]),
                .less    (less_in[i]),
                .sel     (sel),
                .res     (res[i]),
                .cout    (carry[i+1]),
                .set_out (set_bits[i])
            );
        end
    endgenerate

    // Top-slice carries for the overflow and carry-out flags.
    assign msb_cin  = carry[TOP];
    assign msb_cout = carry[W];

endmodule

// File: rtl/alu_flags.sv
// Module: alu_flags
// Derives the status flags from the chain. Overflow is the disagreement
// between the carries into and out of the top slice; zero is the NOR of
// the result bits.
// Assumes: the carries come from the top slice of the same chain.
module alu_flags #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] res,
    input  logic         msb_cin,
    input  logic         msb_cout,
    output logic         ovf,
    output logic         zero
);

    // Signed overflow from the top-slice carry pair.
    assign ovf  = msb_cin ^ msb_cout;

    // Zero detect across the whole result.
    assign zero = ~|res;

endmodule

// File: rtl/bit_slice_alu.sv
// Module: bit_slice_alu
// Top of the combinational bit-sliced ALU. It casts the raw select to the
// slice type and ties the slice chain to the flag logic.
// Assumes: the controller sets carry_in=1 for subtract and set-less-than.
module bit_slice_alu
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic             b_inv,
    input  logic             carry_in,
    input  logic [SEL_W-1:0] op_sel,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             overflow,
    output logic             zero
);

    slice_sel_e sel_e;
    logic       top_cin;
    logic       top_cout;

    // Select decode into the slice enum.
    assign sel_e = slice_sel_e'(op_sel);

    alu_ripple #(
        .W (W)
    ) u_chain (
        .a        (opa),
        .b        (opb),
        .b_inv    (b_inv),
        .cin      (carry_in),
        .sel      (sel_e),
        .res      (result),
        .msb_cin  (top_cin),
        .msb_cout (top_cout)
    );

    alu_flags #(
        .W (W)
    ) u_flags (
        .res      (result),
        .msb_cin  (top_cin),
        .msb_cout (top_cout),
        .ovf      (overflow),
        .zero     (zero)
    );

    // Carry out of the chain.
    assign carry_out = top_cout;

endmodule

// File: rtl/alu_checker.sv
// Module: alu_checker
// Property checks on the ALU ports, evaluated whenever the inputs settle.
// Assumes: it is attached to bit_slice_alu through the bind below.
module alu_checker #(
    parameter int unsigned W = 32
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         b_inv,
    input logic [1:0]   op_sel,
    input logic [W-1:0] result,
    input logic         overflow,
    input logic         zero
);

    logic [W-1:0] bx;
    assign bx = b_inv ? ~opb : opb;

    // Port-level relations between operands, result and flags.
    always_comb begin
        if (op_sel == 2'd0) begin
            a_r1_and_subset: assert ((result & ~opa) == '0)
                else $error("R1: AND result has a 1 outside opa");
        end
        if (op_sel == 2'd1) begin
            a_r2_or_superset: assert ((opa & ~result) == '0)
                else $error("R2: OR result lost a bit of opa");
        end
        if (op_sel == 2'd3) begin
            a_r5_slt_upper_clear: assert (result[W-1:1] == '0)
                else $error("R5: set-less-than drove upper bits");
        end
        if (op_sel == 2'd2 && overflow) begin
            a_r6_overflow_sign: assert (opa[W-1] == bx[W-1] && result[W-1] != opa[W-1])
                else $error("R6: overflow without a sign flip");
        end
        if (opa[W-1] != bx[W-1]) begin
            a_r7_no_overflow: assert (!overflow)
                else $error("R7: overflow on opposite-sign operands");
        end
        if (op_sel == 2'd3 && result[0]) begin
            a_r9_slt_nonzero: assert (!zero)
                else $error("R9: zero set on a nonzero less result");
        end
    end

endmodule

bind bit_slice_alu alu_checker #(
    .W (W)
) u_alu_checker (
    .opa      (opa),
    .opb      (opb),
    .b_inv    (b_inv),
    .op_sel   (op_sel),
    .result   (result),
    .overflow (overflow),
    .zero     (zero)
);

// File: tb/bit_slice_alu_test.sv
// Bench for bit_slice_alu. A behavioural model on wide integer arithmetic
// produces expected values. They are queued when the stimulus is applied
// and compared one clock phase later.
module bit_slice_alu_test;

    localparam int W = 32;
    localparam logic [3:0] C_AND = 4'b0000;
    localparam logic [3:0] C_OR  = 4'b0001;
    localparam logic [3:0] C_ADD = 4'b0010;
    localparam logic [3:0] C_SUB = 4'b0110;
    localparam logic [3:0] C_SLT = 4'b0111;
    localparam logic [W-1:0] MAXI = 32'h7fff_ffff;
    localparam logic [W-1:0] MINI = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] opa = '0, opb = '0;
    logic b_inv = 1'b0, carry_in = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [W-1:0] result;
    logic carry_out, overflow, zero;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [W+2:0] exp_q [$];

    always #10 clk = ~clk;

    bit_slice_alu #(.W(W)) uut (
        .opa(opa), .opb(opb), .b_inv(b_inv), .carry_in(carry_in),
        .op_sel(op_sel), .result(result), .carry_out(carry_out),
        .overflow(overflow), .zero(zero)
    );

    // Behavioural reference: returns {result, carry_out, overflow, zero}.
    function automatic logic [W+2:0] model(input logic [3:0] c,
                                           input logic [W-1:0] a, b,
                                           input logic ci);
        logic [W-1:0] bb, s, r;
        logic [W:0] full;
        logic v;
        bb = c[2] ? ~b : b;
        full = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, ci};
        s = full[W-1:0];
        v = (a[W-1] == bb[W-1]) && (s[W-1] != a[W-1]);
        case (c[1:0])
            2'd0: r = a & bb;
            2'd1: r = a | bb;
            2'd2: r = s;
            default: r = {{(W-1){1'b0}}, s[W-1]};
        endcase
        return {r, full[W], v, (r == '0)};
    endfunction

    // Drive on the rising edge, compare on the falling edge.
    task automatic run(input string tag, input logic [3:0] c,
                       input logic [W-1:0] a, b, input logic ci);
        logic [W+2:0] e, g;
        @(posedge clk);
        opa = a; opb = b; b_inv = c[2]; op_sel = c[1:0]; carry_in = ci;
        exp_q.push_back(model(c, a, b, ci));
        @(negedge clk);
        e = exp_q.pop_front();
        g = {result, carry_out, overflow, zero};
        n_cmp++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s ctrl=%b a=%h b=%h cin=%b: got res=%h c=%b v=%b z=%b, expected res=%h c=%b v=%b z=%b",
                     tag, c, a, b, ci, g[W+2:3], g[2], g[1], g[0],
                     e[W+2:3], e[2], e[1], e[0]);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] x;
        logic [3:0] codes [5];
        codes[0] = C_AND; codes[1] = C_OR; codes[2] = C_ADD;
        codes[3] = C_SUB; codes[4] = C_SLT;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: AND of zeros gives zero result, zero flag (R9).
        run("R9 idle", C_AND, '0, '0, 1'b0);
        // R1 and R2 patterns, with and without inversion.
        run("R1 and", C_AND, 32'hf0f0_1234, 32'hff00_ff0f, 1'b0);
        run("R1 and-inv", 4'b0100, 32'hdead_beef, 32'h0000_ffff, 1'b0);
        run("R2 or", C_OR, 32'h1200_0034, 32'h0056_7800, 1'b0);
        run("R2 or-inv", 4'b0101, 32'h0000_0001, 32'hffff_fffe, 1'b0);
        // R3 add corners.
        run("R3 add", C_ADD, 32'd5, 32'd3, 1'b0);
        run("R3 add-cin", C_ADD, 32'd5, 32'd3, 1'b1);
        run("R6 maxint+1", C_ADD, MAXI, 32'd1, 1'b0);
        run("R6 minint+minint", C_ADD, MINI, MINI, 1'b0);
        run("R8 -1+1", C_ADD, 32'hffff_ffff, 32'd1, 1'b0);
        run("R7 mixed", C_ADD, MAXI, 32'hffff_ffff, 1'b0);
        // R4 subtract corners.
        run("R4 sub", C_SUB, 32'd7, 32'd6, 1'b1);
        run("R4 0-minint", C_SUB, 32'd0, MINI, 1'b1);
        run("R4 minint-1", C_SUB, MINI, 32'd1, 1'b1);
        run("R4 maxint-(-1)", C_SUB, MAXI, 32'hffff_ffff, 1'b1);
        run("R9 x-x", C_SUB, 32'h1234_5678, 32'h1234_5678, 1'b1);
        // R5 set-less-than, including the overflow inversion.
        run("R5 -5<3", C_SLT, 32'hffff_fffb, 32'd3, 1'b1);
        run("R5 3<-5", C_SLT, 32'd3, 32'hffff_fffb, 1'b1);
        run("R5 equal", C_SLT, 32'd9, 32'd9, 1'b1);
        run("R5 maxint<minint", C_SLT, MAXI, MINI, 1'b1);
        run("R5 minint<maxint", C_SLT, MINI, MAXI, 1'b1);
        // R8 carry out reported under AND.
        run("R8 carry-and", C_AND, 32'hffff_ffff, 32'h8000_0001, 1'b0);
        // Pseudo-random sweep across all codes (R1..R9).
        x = 32'h1357_9bdf;
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra;
            logic [3:0] c;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            ra = x;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            c = codes[i % 5];
            run("R3 R6 R8 sweep", c, ra, x, c[2]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule